// File: doc/BRIEF.md
# Serial Panel Register Write Sequencer

This block configures a small TFT display controller through a write-only serial link. Every register write goes out as two separate 24-bit frames. The first frame selects the register number and the second carries the 16-bit value. A host raises one of three commands to run a short, fixed sequence of writes:

- **Start** wakes the panel and programs its output mode.
- **Shutdown** puts the panel to sleep.
- **Resume** reprograms the output mode and then wakes the panel.

The host reads a busy level and a one-cycle done pulse to know when the sequence has finished. The block also drives a backlight enable whose edges are ordered around the sequences. The backlight turns on after the panel is awake and turns off before the panel is put to sleep.

The 16-bit output-mode word is built from a fixed base value. A parameterised set of option bits in the base is replaced by the matching bits of the host's `mode_sel` input. The host's other bits are discarded. The serial clock is derived from the system clock by a parameterised divider.

Top module: `lcd_panel_cfg_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `spi_cs_n` is 1 and `spi_sclk`, `spi_mosi`, `busy`, `done` and `backlight_en` are 0.
- R2: A register-select frame is 24 bits: byte 0x74, then byte 0x00, then the 8-bit register number.
- R3: A value frame is 24 bits: byte 0x76, then the value's upper byte, then its lower byte. Within one register write, the select frame always comes first. Between the two frames, `spi_cs_n` returns high for at least HALF_DIV clock cycles.
- R4: The link runs in SPI mode 0, most significant bit first:
  - `spi_sclk` idles low and rises only while `spi_cs_n` is low.
  - `spi_mosi` does not change while `spi_sclk` is high.
  - Rising edges within a frame are 2*HALF_DIV clock cycles apart.
- R5: Start writes 0x0000 to register 0x11, then writes the mode word to register 0x01.
- R6: Shutdown writes 0x0001 to register 0x11 and nothing else.
- R7: Resume writes the mode word to register 0x01, then writes 0x0000 to register 0x11.
- R8: The mode word is (0x2AEF AND NOT OPT_MASK) OR (`mode_sel` AND OPT_MASK). The default OPT_MASK is 0x3A00, which covers bits 13, 12, 11 and 9. Bits of `mode_sel` outside the mask have no effect. `mode_sel` is sampled when the command is accepted.
- R9: `busy` rises in the cycle after a command is accepted. It stays high until the last frame of the sequence has ended. `done` pulses for exactly one cycle, in the same cycle that `busy` falls.
- R10: `backlight_en` rises with `done` at the end of a start or resume sequence. It falls in the cycle after a shutdown is accepted, before the first frame's `spi_cs_n` goes low.
- R11: Commands raised while `busy` is high are ignored.
- R12: When several commands are raised in the same idle cycle, shutdown takes precedence over resume, and resume over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Request the wake-and-program sequence |
| cmd_shutdown | input | 1 | Request the sleep sequence |
| cmd_resume | input | 1 | Request the reprogram-and-wake sequence |
| mode_sel | input | 16 | Host option bits for the output-mode word |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence finishes |
| backlight_en | output | 1 | Backlight enable |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_cs_n | output | 1 | Active-low frame select |

## Verification
Two things can collide in one cycle.

The first is command arbitration. The bench raises start with shutdown, all three commands at once, and resume with start, each pair or set on the same clock edge. It judges the winner by the register writes that actually appear on the serial pins.

The second is a new command arriving during a running sequence. The bench raises shutdown partway through a start sequence. The total frame count and the final backlight level confirm that the late request left no trace.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [1:0] {
    OP_START  = 2'd0,
    OP_SHUT   = 2'd1,
    OP_RESUME = 2'd2
  } pcfg_op_e;

  localparam logic [7:0]  SEL_PREFIX   = 8'h74;
  localparam logic [7:0]  VAL_PREFIX   = 8'h76;
  localparam logic [7:0]  REG_SLEEP    = 8'h11;
  localparam logic [7:0]  REG_OUTMODE  = 8'h01;
  localparam logic [15:0] MODE_BASE    = 16'h2AEF;
  localparam logic [15:0] SLEEP_ON     = 16'h0001;
  localparam logic [15:0] SLEEP_OFF    = 16'h0000;

endpackage

// File: rtl/pcfg_clkdiv.sv
module pcfg_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  generate
    if (HALF_DIV <= 1) begin : g_full
      assign tick = en;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || !en) begin
          cnt <= '0;
        end else if (cnt == TOP) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign tick = en && (cnt == TOP);
    end
  endgenerate

endmodule

// File: rtl/pcfg_frame_tx.sv
module pcfg_frame_tx #(
  parameter int HALF_DIV   = 4,
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [FRAME_BITS-1:0] data,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  cs_n,
  output logic                  busy,
  output logic                  done
);

  localparam int PH_N = 2 * FRAME_BITS;
  localparam int PH_W = $clog2(PH_N);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

  typedef enum logic [1:0] {F_IDLE, F_ACT, F_TAIL, F_GAP} fst_e;

  fst_e                  st;
  logic [FRAME_BITS-1:0] sh;
  logic [PH_W-1:0]       ph;
  logic                  tick;

  pcfg_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (st != F_IDLE),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= F_IDLE;
      sh   <= '0;
      ph   <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      cs_n <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        F_IDLE: begin
          if (go) begin
            cs_n <= 1'b0;
            mosi <= data[FRAME_BITS-1];
            sh   <= data << 1;
            ph   <= '0;
            st   <= F_ACT;
          end
        end
        F_ACT: begin
          if (tick) begin
            ph <= ph + 1'b1;
            if (!ph[0]) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (ph == PH_LAST) begin
                st <= F_TAIL;
              end else begin
                mosi <= sh[FRAME_BITS-1];
                sh   <= sh << 1;
              end
            end
          end
        end
        F_TAIL: begin
          if (tick) begin
            cs_n <= 1'b1;
            mosi <= 1'b0;
            st   <= F_GAP;
          end
        end
        F_GAP: begin
          if (tick) begin
            done <= 1'b1;
            st   <= F_IDLE;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign busy = (st != F_IDLE);

  // R4: clock only toggles inside a frame
  a_r4_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R4: data held while the clock is high
  a_r4_mosi_steady: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

endmodule

// File: rtl/pcfg_reg_writer.sv
module pcfg_reg_writer
  import pcfg_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic [7:0]  reg_num,
  input  logic [15:0] value,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  output logic        busy,
  output logic        done
);

  typedef enum logic [1:0] {W_IDLE, W_SEL, W_VAL} wst_e;

  wst_e        st;
  logic        f_go;
  logic [23:0] f_data;
  logic [15:0] val_q;
  logic        f_busy;
  logic        f_done;

  pcfg_frame_tx #(.HALF_DIV(HALF_DIV), .FRAME_BITS(24)) u_frame (
    .clk  (clk),
    .rst  (rst),
    .go   (f_go),
    .data (f_data),
    .sclk (sclk),
    .mosi (mosi),
    .cs_n (cs_n),
    .busy (f_busy),
    .done (f_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= W_IDLE;
      f_go   <= 1'b0;
      f_data <= '0;
      val_q  <= '0;
      done   <= 1'b0;
    end else begin
      f_go <= 1'b0;
      done <= 1'b0;
      unique case (st)
        W_IDLE: begin
          if (go) begin
            f_go   <= 1'b1;
            f_data <= {SEL_PREFIX, 8'h00, reg_num};
            val_q  <= value;
            st     <= W_SEL;
          end
        end
        W_SEL: begin
          if (f_done) begin
            f_go   <= 1'b1;
            f_data <= {VAL_PREFIX, val_q};
            st     <= W_VAL;
          end
        end
        W_VAL: begin
          if (f_done) begin
            done <= 1'b1;
            st   <= W_IDLE;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign busy = (st != W_IDLE);

  // R3: the frame engine is never active while the writer is idle
  a_r3_frame_owned: assert property (@(posedge clk) disable iff (rst)
    (st == W_IDLE) |-> !f_busy);

  // R9: completion is a single-cycle pulse
  a_r9_wr_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/lcd_panel_cfg_seq.sv
module lcd_panel_cfg_seq
  import pcfg_pkg::*;
#(
  parameter int          HALF_DIV = 4,
  parameter logic [15:0] OPT_MASK = 16'h3A00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_start,
  input  logic        cmd_shutdown,
  input  logic        cmd_resume,
  input  logic [15:0] mode_sel,
  output logic        busy,
  output logic        done,
  output logic        backlight_en,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_cs_n
);

  localparam logic [15:0] MODE_FIXED = MODE_BASE & ~OPT_MASK;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} sst_e;

  sst_e        st;
  pcfg_op_e    op_q;
  logic        step_q;
  logic [15:0] mode_q;
  logic [15:0] mode_now;
  logic        any_cmd;
  pcfg_op_e    op_pick;

  logic        wr_go;
  logic [7:0]  wr_reg;
  logic [15:0] wr_val;
  logic        wr_busy;
  logic        wr_done;
  logic [7:0]  cur_reg;
  logic [15:0] cur_val;
  logic        cur_last;

  always_comb begin
    mode_now = MODE_FIXED | (mode_sel & OPT_MASK);
    any_cmd  = cmd_start | cmd_shutdown | cmd_resume;
    if (cmd_shutdown)    op_pick = OP_SHUT;
    else if (cmd_resume) op_pick = OP_RESUME;
    else                 op_pick = OP_START;
  end

  always_comb begin
    cur_reg  = REG_SLEEP;
    cur_val  = SLEEP_OFF;
    cur_last = 1'b1;
    unique case (op_q)
      OP_START: begin
        cur_reg  = step_q ? REG_OUTMODE : REG_SLEEP;
        cur_val  = step_q ? mode_q      : SLEEP_OFF;
        cur_last = step_q;
      end
      OP_RESUME: begin
        cur_reg  = step_q ? REG_SLEEP : REG_OUTMODE;
        cur_val  = step_q ? SLEEP_OFF : mode_q;
        cur_last = step_q;
      end
      OP_SHUT: begin
        cur_reg  = REG_SLEEP;
        cur_val  = SLEEP_ON;
        cur_last = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      op_q         <= OP_START;
      step_q       <= 1'b0;
      mode_q       <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      backlight_en <= 1'b0;
      wr_go        <= 1'b0;
      wr_reg       <= '0;
      wr_val       <= '0;
    end else begin
      done  <= 1'b0;
      wr_go <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (any_cmd) begin
            op_q   <= op_pick;
            mode_q <= mode_now;
            step_q <= 1'b0;
            busy   <= 1'b1;
            if (op_pick == OP_SHUT) backlight_en <= 1'b0;
            st     <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          wr_go  <= 1'b1;
          wr_reg <= cur_reg;
          wr_val <= cur_val;
          st     <= S_WAIT;
        end
        S_WAIT: begin
          if (wr_done) begin
            if (cur_last) begin
              busy <= 1'b0;
              done <= 1'b1;
              if (op_q != OP_SHUT) backlight_en <= 1'b1;
              st   <= S_IDLE;
            end else begin
              step_q <= 1'b1;
              st     <= S_ISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  pcfg_reg_writer #(.HALF_DIV(HALF_DIV)) u_writer (
    .clk     (clk),
    .rst     (rst),
    .go      (wr_go),
    .reg_num (wr_reg),
    .value   (wr_val),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .cs_n    (spi_cs_n),
    .busy    (wr_busy),
    .done    (wr_done)
  );

  // R9: no frame outside a sequence
  a_r9_frame_needs_busy: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> busy);

  // R9: done and busy never overlap
  a_r9_done_clears_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: backlight stays dark for the whole shutdown sequence
  a_r10_dark_in_shutdown: assert property (@(posedge clk) disable iff (rst)
    (busy && op_q == OP_SHUT) |-> !backlight_en);

  // R11: the writer is quiet whenever the sequencer is idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !wr_busy);

endmodule

// File: tb/lcd_panel_cfg_seq_test.sv
module lcd_panel_cfg_seq_test;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic        cmd_shutdown = 1'b0;
  logic        cmd_resume = 1'b0;
  logic [15:0] mode_sel = 16'h0000;
  logic        busy, done, backlight_en, spi_sclk, spi_mosi, spi_cs_n;

  int errors = 0;
  int checks = 0;

  lcd_panel_cfg_seq #(.HALF_DIV(HALF), .OPT_MASK(16'h3A00)) uut (
    .clk          (clk),
    .rst          (rst),
    .cmd_start    (cmd_start),
    .cmd_shutdown (cmd_shutdown),
    .cmd_resume   (cmd_resume),
    .mode_sel     (mode_sel),
    .busy         (busy),
    .done         (done),
    .backlight_en (backlight_en),
    .spi_sclk     (spi_sclk),
    .spi_mosi     (spi_mosi),
    .spi_cs_n     (spi_cs_n)
  );

  always #4 clk = ~clk;

  // serial monitor
  int          cyc = 0;
  logic        mon_en = 1'b0;
  logic [23:0] shreg = '0;
  int          nbits = 0;
  logic [23:0] frames [0:7];
  int          nfr = 0;
  int          bad_bits = 0;
  int          bad_period = 0;
  int          min_gap = 1000;
  int          last_rise = -1;
  int          last_csup = -1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge spi_sclk) begin
    if (mon_en && !spi_cs_n) begin
      shreg = {shreg[22:0], spi_mosi};
      nbits = nbits + 1;
      if (last_rise >= 0 && (cyc - last_rise) != 2 * HALF) bad_period++;
      last_rise = cyc;
    end
  end

  always @(negedge spi_cs_n) begin
    if (mon_en) begin
      nbits = 0;
      last_rise = -1;
      if (last_csup >= 0 && (cyc - last_csup) < min_gap) min_gap = cyc - last_csup;
    end
  end

  always @(posedge spi_cs_n) begin
    if (mon_en) begin
      if (nbits != 24) bad_bits++;
      if (nfr < 8) frames[nfr] = shreg;
      nfr = nfr + 1;
      last_csup = cyc;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    nfr = 0;
    bad_bits = 0;
    bad_period = 0;
    min_gap = 1000;
    last_csup = -1;
  endtask

  task automatic raise(input bit s, input bit sh, input bit r, input logic [15:0] m);
    @(negedge clk);
    cmd_start = s; cmd_shutdown = sh; cmd_resume = r; mode_sel = m;
    @(negedge clk);
    cmd_start = 0; cmd_shutdown = 0; cmd_resume = 0;
  endtask

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(seen, {tag, " done pulse"}, 32'(seen), 1);
    check(!busy, {tag, " busy falls with done"}, 32'(busy), 0);
    @(negedge clk);
    check(!done, {tag, " done one cycle"}, 32'(done), 0);
  endtask

  task automatic expect_write(input int k, input logic [7:0] r, input logic [15:0] v,
                              input string tag);
    check(frames[2*k] == {8'h74, 8'h00, r}, {tag, " select frame"},
          32'(frames[2*k]), {8'h00, 8'h74, 8'h00, r});
    check(frames[2*k+1] == {8'h76, v}, {tag, " value frame"},
          32'(frames[2*k+1]), {8'h00, 8'h76, v});
  endtask

  task automatic frame_hygiene(input string tag);
    check(bad_bits == 0, {tag, " R4 24 bits per frame"}, 32'(bad_bits), 0);
    check(bad_period == 0, {tag, " R4 sclk period"}, 32'(bad_period), 0);
    check(min_gap >= HALF, {tag, " R3 cs gap"}, 32'(min_gap), HALF);
  endtask

  task automatic t_reset();
    check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && spi_mosi === 1'b0,
          "R1 spi idle", {29'd0, spi_cs_n, spi_sclk, spi_mosi}, 32'b100);
    check(busy === 1'b0 && done === 1'b0 && backlight_en === 1'b0,
          "R1 host idle", {29'd0, busy, done, backlight_en}, 0);
  endtask

  task automatic t_start();
    clear_mon();
    raise(1, 0, 0, 16'hFFFF);
    check(busy, "R9 busy after accept", 32'(busy), 1);
    wait_done("R5 start");
    check(nfr == 4, "R5 frame count", nfr, 4);
    expect_write(0, 8'h11, 16'h0000, "R5 R2 R3 wake");
    expect_write(1, 8'h01, 16'h3AEF, "R5 R8 mode all options");
    check(backlight_en, "R10 backlight on after start", 32'(backlight_en), 1);
    frame_hygiene("R5");
  endtask

  task automatic t_shutdown();
    clear_mon();
    raise(0, 1, 0, 16'h0000);
    check(!backlight_en && spi_cs_n, "R10 backlight off before frames",
          {30'd0, backlight_en, spi_cs_n}, 32'b01);
    wait_done("R6 shutdown");
    check(nfr == 2, "R6 frame count", nfr, 2);
    expect_write(0, 8'h11, 16'h0001, "R6 sleep");
    check(!backlight_en, "R10 backlight stays off", 32'(backlight_en), 0);
  endtask

  task automatic t_resume();
    clear_mon();
    raise(0, 0, 1, 16'h0500);
    wait_done("R7 resume");
    check(nfr == 4, "R7 frame count", nfr, 4);
    expect_write(0, 8'h01, 16'h00EF, "R7 R8 mode ignores unmasked bits");
    expect_write(1, 8'h11, 16'h0000, "R7 wake last");
    check(backlight_en, "R10 backlight on after resume", 32'(backlight_en), 1);
    frame_hygiene("R7");
  endtask

  task automatic t_busy_ignore();
    clear_mon();
    raise(1, 0, 0, 16'h2200);
    repeat (20) @(negedge clk);
    raise(0, 1, 0, 16'h0000);
    repeat (200) @(negedge clk);
    raise(0, 0, 1, 16'h0000);
    wait_done("R11 busy ignore");
    check(nfr == 4, "R11 frame count", nfr, 4);
    expect_write(1, 8'h01, 16'h22EF, "R11 R8 start mode");
    check(backlight_en, "R11 backlight unaffected", 32'(backlight_en), 1);
    repeat (20) @(negedge clk);
    check(nfr == 4 && !busy, "R11 no late sequence", nfr, 4);
  endtask

  task automatic t_collide();
    clear_mon();
    raise(1, 1, 0, 16'hFFFF);
    wait_done("R12 start+shut");
    check(nfr == 2, "R12 shut beats start count", nfr, 2);
    expect_write(0, 8'h11, 16'h0001, "R12 shut beats start");
    clear_mon();
    raise(1, 1, 1, 16'hFFFF);
    wait_done("R12 all three");
    check(nfr == 2, "R12 shut beats all count", nfr, 2);
    expect_write(0, 8'h11, 16'h0001, "R12 shut beats all");
    clear_mon();
    raise(1, 0, 1, 16'h1800);
    wait_done("R12 resume+start");
    check(nfr == 4, "R12 resume count", nfr, 4);
    expect_write(0, 8'h01, 16'h18EF, "R12 resume beats start");
    expect_write(1, 8'h11, 16'h0000, "R12 resume wake");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    mon_en = 1'b1;
    t_start();
    t_shutdown();
    t_resume();
    t_busy_ignore();
    t_collide();
    finish_run();
  end

endmodule